// File: doc/BRIEF.md
# Tick-Counted Multi-Channel PWM Controller

This block generates several independent pulse-width-modulated outputs. Each channel is set up through one 32-bit control word that software writes over a simple memory-mapped bus. The word holds an enable flag, a high-time count and a clock divider setting. Each channel divides the block clock by its divider setting to make a tick. A period is always 256 ticks long. The output is high for the first N ticks of each period and low for the rest, where N is the high-time count.

A channel reloads its divider and high-time values only at a period boundary. A value written in the middle of a period therefore never produces a shortened or extra pulse. Turning a channel on restarts its period from tick zero. Turning it off forces its output low and parks its counters at zero. The number of channels is a parameter: four by default, and one is also supported.

Top module: `tickpwm_top`

## Requirements
- R1: After reset every channel word reads back as zero and every output is low.
- R2: Channel k's word sits at byte address 16·k. Bit 31 is the enable flag, bits 24:16 are the high-time count and bits 12:0 are the divider setting. A read returns all 32 bits of the last value written to that word.
- R3: An address whose low four bits are non-zero, or whose index (address bits above bit 3) is not below the channel count, is not a channel word. A write to it changes no channel word, and a read of it returns zero.
- R4: With divider setting P, one tick lasts P+1 clock cycles (a setting of 0 gives one cycle per tick), and one period lasts 256 ticks.
- R5: With a high-time count D below 256, the output is high during ticks 0 to D−1 of each period and low for the rest. A count of 0 keeps the output low for the whole period.
- R6: A high-time count of 256 or more (bit 24 set) keeps the output high for the whole period.
- R7: A write that sets bit 31 on a disabled channel loads the written high-time count and divider setting at once. Tick 0 of a fresh period starts in the next cycle.
- R8: A write with bit 31 clear (including a write of zero) drives the channel's output low from the next cycle on and holds its counters at zero until the channel is enabled again.
- R9: A write that changes the high-time count or divider setting of a running channel takes effect at the start of the first period that begins after the write.
- R10: Channels run independently. A write to one channel does not disturb the output of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe; the write happens at the rising clock edge |
| addr | input | ADDR_W | Byte address for both read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| pwmOut | output | NUM_CH | One PWM output per channel |

## Verification
The assertions assume that a write is a single-cycle strobe whose address and data are stable around the clock edge. They also assume that reads are plain combinational decodes of `addr`, with no side effect. The readback property assumes that when the address stays on a written word for the next cycle, no second write to that word is issued. The stimulus drives all inputs on the falling edge and holds the write strobe for exactly one cycle. It keeps divider settings small enough that several full periods fit in the run. It compares every output on every cycle against a behavioural model that tracks pending and active settings separately.

// File: rtl/tickpwm_pkg.sv
package tickpwm_pkg;
  localparam int EN_BIT       = 31;
  localparam int DUTY_LSB     = 16;
  localparam int DUTY_W       = 9;
  localparam int PRESC_LSB    = 0;
  localparam int PRESC_W      = 13;
  localparam int STRIDE_LOG2  = 4;
  localparam int PERIOD_TICKS = 256;
  localparam int TICK_W       = $clog2(PERIOD_TICKS);

  typedef struct packed {
    logic                start;
    logic                en;
    logic [DUTY_W-1:0]   duty;
    logic [PRESC_W-1:0]  presc;
  } chCtl_t;
endpackage

// File: rtl/tickpwm_regs.sv
module tickpwm_regs
  import tickpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wrData,
  output logic [31:0]             rdData,
  output chCtl_t [NUM_CH-1:0]     chCtl
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [31:0]        ctlReg [NUM_CH];
  logic               wordAligned;
  logic [IDX_W-1:0]   chIdx;
  logic [NUM_CH-1:0]  selVec;

  assign wordAligned = (addr[STRIDE_LOG2-1:0] == '0);
  assign chIdx       = addr[ADDR_W-1:STRIDE_LOG2];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign selVec[g] = wordAligned && (chIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlReg[g] <= '0;
      end else if (wrEn && selVec[g]) begin
        ctlReg[g] <= wrData;
      end
    end

    logic startNow;
    assign startNow = wrEn && selVec[g] && wrData[EN_BIT] && !ctlReg[g][EN_BIT];

    assign chCtl[g].start = startNow;
    assign chCtl[g].en    = ctlReg[g][EN_BIT];
    assign chCtl[g].duty  = startNow ? wrData[DUTY_LSB +: DUTY_W]
                                     : ctlReg[g][DUTY_LSB +: DUTY_W];
    assign chCtl[g].presc = startNow ? wrData[PRESC_LSB +: PRESC_W]
                                     : ctlReg[g][PRESC_LSB +: PRESC_W];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (selVec[i]) rdData = ctlReg[i];
    end
  end
endmodule

// File: rtl/tickpwm_datapath.sv
module tickpwm_datapath
  import tickpwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chCtl_t [NUM_CH-1:0]  chCtl,
  output logic [NUM_CH-1:0]    pwmOut
);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PERIOD_TICKS - 1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [PRESC_W-1:0] preCnt;
    logic [PRESC_W-1:0] actPresc;
    logic [TICK_W-1:0]  tickCnt;
    logic [DUTY_W-1:0]  actDuty;
    logic               tickHit;
    logic               wrapHit;

    assign tickHit = (preCnt == actPresc);
    assign wrapHit = tickHit && (tickCnt == LAST_TICK);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preCnt   <= '0;
        tickCnt  <= '0;
        actPresc <= '0;
        actDuty  <= '0;
      end else if (chCtl[g].start) begin
        preCnt   <= '0;
        tickCnt  <= '0;
        actPresc <= chCtl[g].presc;
        actDuty  <= chCtl[g].duty;
      end else if (!chCtl[g].en) begin
        preCnt   <= '0;
        tickCnt  <= '0;
      end else if (tickHit) begin
        preCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
        if (wrapHit) begin
          actPresc <= chCtl[g].presc;
          actDuty  <= chCtl[g].duty;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end

    assign pwmOut[g] = chCtl[g].en && ({1'b0, tickCnt} < actDuty);
  end
endmodule

// File: rtl/tickpwm_top.sv
module tickpwm_top
  import tickpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic [NUM_CH-1:0]  pwmOut
);
  chCtl_t [NUM_CH-1:0] chCtl;

  tickpwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .chCtl  (chCtl)
  );

  tickpwm_datapath #(.NUM_CH(NUM_CH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .chCtl  (chCtl),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/tickpwm_checker.sv
module tickpwm_checker
  import tickpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          wrData,
  input logic [31:0]          rdData,
  input logic [NUM_CH-1:0]    pwmOut,
  input chCtl_t [NUM_CH-1:0]  chCtl
);
  // R1: the first sampled cycle after reset release reads zero
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (rdData == 32'h0));

  // R3: misaligned addresses never return data
  p_unused_read_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (addr[STRIDE_LOG2-1:0] != '0) |-> (rdData == 32'h0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(g << STRIDE_LOG2);

    // R2: a written word reads back unchanged in the following cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == CH_ADDR) |=> ((addr != CH_ADDR) || (rdData == $past(wrData))));

    // R8: clearing the enable flag silences the output next cycle
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == CH_ADDR && !wrData[EN_BIT]) |=> !pwmOut[g]);

    // R7: a fresh start with a non-zero count begins high at tick 0
    p_start_high_r7: assert property (@(posedge clk) disable iff (!rstN)
      (chCtl[g].start && chCtl[g].duty != '0) |=> pwmOut[g]);

    // R5: a fresh start with a zero count stays low
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rstN)
      (chCtl[g].start && chCtl[g].duty == '0) |=> !pwmOut[g]);

    // R4: a start always carries the divider setting of the write
    p_start_presc_r4: assert property (@(posedge clk) disable iff (!rstN)
      chCtl[g].start |-> (wrEn && chCtl[g].presc == wrData[PRESC_LSB +: PRESC_W]
                          && !chCtl[g].en));
  end
endmodule

bind tickpwm_top tickpwm_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .pwmOut (pwmOut),
  .chCtl  (chCtl)
);

// File: tb/tickpwm_tb_top.sv
`timescale 1ns/1ps
module tickpwm_tb_top;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] pwmOut;

  always #2 clk = ~clk;

  tickpwm_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  int cycleCnt = 0;
  bit finished = 0;
  bit compareOn = 0;
  string curReq = "R1";

  // Behavioural reference: word contents plus active settings and counters
  logic [31:0] mWord [NUM_CH];
  int mActDuty [NUM_CH];
  int mActDiv  [NUM_CH];
  int mSub     [NUM_CH];
  int mTick    [NUM_CH];

  function automatic bit mEnabled(int c);
    return mWord[c][31];
  endfunction

  function automatic logic [31:0] expRead(logic [ADDR_W-1:0] a);
    if (a[3:0] != 4'h0) return 32'h0;
    if (int'(a[ADDR_W-1:4]) >= NUM_CH) return 32'h0;
    return mWord[int'(a[ADDR_W-1:4])];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        mWord[c] = 32'h0; mActDuty[c] = 0; mActDiv[c] = 1; mSub[c] = 0; mTick[c] = 0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        bit hit;
        hit = wrEn && (addr == ADDR_W'(c * 16));
        if (hit && wrData[31] && !mEnabled(c)) begin
          mActDuty[c] = int'(wrData[24:16]);
          mActDiv[c]  = int'(wrData[12:0]) + 1;
          mSub[c] = 0; mTick[c] = 0;
        end else if (!mEnabled(c)) begin
          mSub[c] = 0; mTick[c] = 0;
        end else begin
          mSub[c]++;
          if (mSub[c] == mActDiv[c]) begin
            mSub[c] = 0;
            mTick[c]++;
            if (mTick[c] == 256) begin
              mTick[c] = 0;
              mActDuty[c] = int'(mWord[c][24:16]);
              mActDiv[c]  = int'(mWord[c][12:0]) + 1;
            end
          end
        end
        if (hit) mWord[c] = wrData;
      end
    end
  end

  task automatic check1(string req, logic [31:0] act, logic [31:0] exp, string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", req, what, act, exp, cycleCnt);
    end
  endtask

  // Per-cycle output comparison against the model
  always @(negedge clk) begin
    if (rstN && compareOn && !finished) begin
      for (int c = 0; c < NUM_CH; c++) begin
        logic expOut;
        expOut = mEnabled(c) && (mTick[c] < mActDuty[c]);
        check1(curReq, {31'h0, pwmOut[c]}, {31'h0, expOut}, $sformatf("pwmOut[%0d]", c));
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdChk(string req, int a);
    @(negedge clk);
    wrEn = 1'b0; addr = ADDR_W'(a);
    #1;
    check1(req, rdData, expRead(ADDR_W'(a)), $sformatf("read @%0h", a));
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000 && !finished) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
    end
  end

  function automatic logic [31:0] word(bit en, int duty, int presc);
    return {en, 6'h0, 9'(duty), 3'h0, 13'(presc)};
  endfunction

  initial begin
    run(3);
    rstN = 1'b1;
    // R1: reset state of words and outputs
    curReq = "R1";
    compareOn = 1;
    for (int c = 0; c < NUM_CH; c++) rdChk("R1", c * 16);
    check1("R1", {28'h0, pwmOut}, 32'h0, "outputs after reset");

    // R7 R5 R4: start ch0 with count 64, divide by 1
    curReq = "R5 R4 R7 ch0";
    wr(16'h00, word(1, 64, 0));
    run(600);

    // R6: ch1 full high via bit 24, divide by 2; R5 zero count on ch2; R10 ch3
    curReq = "R6 R5 R10";
    wr(16'h10, word(1, 256, 1));
    wr(16'h20, word(1, 0, 0));
    wr(16'h30, word(1, 200, 3));
    run(2200);

    // R2: full 32-bit readback and field positions
    curReq = "R2 R10";
    wr(16'h20, 32'h8A55_1234);
    rdChk("R2", 16'h20);
    for (int c = 0; c < NUM_CH; c++) rdChk("R2", c * 16);
    wr(16'h20, word(1, 5, 0));
    rdChk("R2", 16'h20);
    run(300);

    // R9: mid-period change on running ch0
    curReq = "R9";
    run(37);
    wr(16'h00, word(1, 128, 1));
    rdChk("R9", 16'h00);
    run(1200);
    wr(16'h00, word(1, 10, 2));
    run(2000);

    // R3: writes to non-word addresses are ignored, reads return zero
    curReq = "R3";
    wr(16'h04, 32'hFFFF_FFFF);
    wr(16'h14, 32'h0000_0000);
    wr(16'h40, 32'h8001_0000);
    wr(16'hF0, 32'h0000_0000);
    rdChk("R3", 16'h04);
    rdChk("R3", 16'h14);
    rdChk("R3", 16'h40);
    rdChk("R3", 16'hF0);
    for (int c = 0; c < NUM_CH; c++) rdChk("R3", c * 16);
    run(50);

    // R8: write zero disables and clears; R7 re-enable starts fresh
    curReq = "R8";
    wr(16'h30, 32'h0);
    rdChk("R8", 16'h30);
    check1("R8", {31'h0, pwmOut[3]}, 32'h0, "ch3 low after zero write");
    run(400);
    wr(16'h10, word(0, 256, 1));
    run(300);
    curReq = "R7";
    wr(16'h30, word(1, 3, 0));
    run(900);
    wr(16'h10, word(1, 255, 0));
    run(600);

    compareOn = 0;
    summary();
  end
endmodule